// File: doc/BRIEF.md
# I2C Serial Memory Slave Interface

This block is the bus-facing front end of a 256-byte serial memory. It runs on a fast system clock and oversamples the two-wire bus lines. It finds Start and Stop conditions and shifts bytes in and out MSB first. It checks the control byte, and it acknowledges by pulling SDA low through an open-drain enable. It keeps one byte-wide pointer, which reads and writes share and which is kept from one transaction to the next.

Writes go out as requests to a separate write engine. Each accepted data byte gives a one-cycle pulse that carries the address and the data. A Stop that closes a write which carried data gives a commit pulse. While the engine raises `busy_i`, the block acknowledges nothing, so a master can poll for the end of an internal write. Reads take the storage array combinationally: `rd_addr_o` gives the address and `rd_data_i` returns the byte. The block supports byte and page writes, reads from the current address, random reads and sequential reads.

Top module: `i2c_mem_slave`

## Requirements
- R1: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. While receiving, each bit is taken from SDA at the rising edge of SCL, most significant bit first.
- R2: The first byte after a Start is the control byte. It is accepted only when bits 7:4 equal 4'b1010. Bits 3:1 are ignored. Bit 0 set to 1 selects a read and bit 0 set to 0 selects a write.
- R3: For each accepted byte, `sda_pull_o` is 1 (SDA low) from shortly after the falling edge of the 8th SCL pulse until the 9th pulse ends. A rejected byte leaves SDA released. Out of reset, `sda_pull_o` is 0 and the pointer (`rd_addr_o`) is 0x00.
- R4: If `busy_i` is high when a byte completes, that byte is not acknowledged, whether it is a control, address or data byte. The pointer and the write outputs keep their values, and the block ignores the bus until the next Start.
- R5: In a write, the byte after the control byte loads the pointer. Each later byte gives one `wr_valid_o` pulse with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte. The pointer's low log2(PAGE_BYTES) bits (three by default) then advance by one and wrap, and the upper bits hold.
- R6: A Stop that ends a write which accepted at least one data byte gives exactly one `wr_stop_o` pulse. A transaction with no data bytes gives no pulse, and that includes a repeated Start right after the address byte.
- R7: Each byte sent in a read is the array byte at the pointer, most significant bit first. The pointer then increments by one and wraps from 0xFF to 0x00. A read that begins without an address byte continues from where the previous access left the pointer.
- R8: During a read, a master ACK (SDA low in the 9th clock) makes the block send the next byte. A master NACK makes it release SDA and ignore the bus until a Start.
- R9: A Start in the middle of a byte restarts reception of a control byte. A Stop in the middle of a byte returns the block to idle, so it acknowledges none of the clocks that follow.
- R10: `sda_pull_o` changes only while the synchronised SCL is low. It changes HOLD_CLKS+1 system clocks after its internal request, and that request moves only after a detected SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_i | input | 1 | Write engine is programming the array |
| rd_addr_o | output | ADDR_W | Array read address (current pointer) |
| rd_data_i | input | DATA_W | Array byte at `rd_addr_o`, combinational |
| wr_valid_o | output | 1 | One-cycle pulse per accepted data byte |
| wr_addr_o | output | ADDR_W | Address of the accepted data byte |
| wr_data_o | output | DATA_W | Value of the accepted data byte |
| wr_stop_o | output | 1 | One-cycle pulse: commit the received write |

## Verification
The assertions assume that the SCL high and low phases each last longer than the synchroniser delay plus the hold delay. They also assume that SDA moves only while SCL is low, except when it forms a Start or Stop, and that the master never makes a Start or Stop while the slave is pulling SDA low. The bench keeps every SCL phase at 20 system clocks and changes SDA 10 clocks into a low phase. It issues a Start or Stop only after the 9th clock, once the slave has released SDA. Random byte writes and reads at random addresses are mixed with directed cases: a control code that does not match, page wrap, repeated Start, a read that wraps from 0xFF to 0x00, busy polling, and aborts in the middle of a byte.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  // Link layer state of the slave
  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring bus until Start
    ST_RX,     // shifting a byte in
    ST_ACK,    // slave pulls SDA during 9th clock
    ST_TX,     // shifting a byte out
    ST_MACK    // sampling master ACK/NACK
  } link_st_e;

  // Meaning of the byte being received
  typedef enum logic [1:0] {
    RX_CTRL,
    RX_ADDR,
    RX_DATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/i2c_sda_hold.sv
module i2c_sda_hold #(
  parameter int HOLD_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pull_req_i,
  input  logic scl_low_i,
  output logic pull_o
);
  localparam int CW = $clog2(HOLD_CLKS + 1) + 1;

  logic [CW-1:0] cnt_q;
  logic          pull_q;

  // A changed request is applied only after HOLD_CLKS+1 clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pull_q <= 1'b0;
    end else if (pull_req_i == pull_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(HOLD_CLKS)) begin
      pull_q <= pull_req_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign pull_o = pull_q;

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(pull_q) |-> $past(scl_low_i)); // R10
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 8,
  parameter int         PAGE_BYTES  = 8,
  parameter int         HOLD_CLKS   = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] CTRL_CODE   = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_stop_o
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int BIT_W  = $clog2(DATA_W + 1);
  localparam int LINES  = 2;

  // Pointer arithmetic: writes stay inside a page, reads walk the array
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + PAGE_W'(1);
    return {a[ADDR_W-1:PAGE_W], lo};
  endfunction

  function automatic logic [ADDR_W-1:0] seq_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic code_match(input logic [DATA_W-1:0] b);
    return b[DATA_W-1 -: 4] == CTRL_CODE;
  endfunction

  // Line synchronisers (index 1 = SCL, index 0 = SDA)
  logic [LINES-1:0] line_raw, line_lvl, line_prev;
  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_raw[g]),
      .lvl_o  (line_lvl[g]),
      .prev_o (line_prev[g])
    );
  end

  logic scl_lvl, scl_prev, sda_lvl, sda_prev;
  assign scl_lvl  = line_lvl[1];
  assign scl_prev = line_prev[1];
  assign sda_lvl  = line_lvl[0];
  assign sda_prev = line_prev[0];

  // Named bus events
  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

  link_st_e          st_q;
  rx_kind_e          kind_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shreg_q, txreg_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              rw_q, mack_q, data_seen_q;
  logic              wr_valid_q, wr_stop_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  logic byte_done, byte_accept, pull_req;
  assign byte_done = (st_q == ST_RX) & scl_fall & (bit_q == BIT_W'(DATA_W));

  always_comb begin
    case (kind_q)
      RX_CTRL: byte_accept = code_match(shreg_q) & ~busy_i;
      default: byte_accept = ~busy_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      kind_q      <= RX_CTRL;
      bit_q       <= '0;
      shreg_q     <= '0;
      txreg_q     <= '0;
      ptr_q       <= '0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      data_seen_q <= 1'b0;
      wr_valid_q  <= 1'b0;
      wr_stop_q   <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      wr_valid_q <= 1'b0;
      wr_stop_q  <= 1'b0;
      if (start_det) begin
        st_q        <= ST_RX;
        kind_q      <= RX_CTRL;
        bit_q       <= '0;
        data_seen_q <= 1'b0;
      end else if (stop_det) begin
        st_q        <= ST_IDLE;
        wr_stop_q   <= data_seen_q;
        data_seen_q <= 1'b0;
      end else begin
        case (st_q)
          ST_RX: begin
            if (scl_rise && bit_q != BIT_W'(DATA_W)) begin
              shreg_q <= {shreg_q[DATA_W-2:0], sda_lvl};
              bit_q   <= bit_q + BIT_W'(1);
            end else if (byte_done) begin
              if (byte_accept) begin
                st_q <= ST_ACK;
                case (kind_q)
                  RX_CTRL: rw_q  <= shreg_q[0];
                  RX_ADDR: ptr_q <= shreg_q[ADDR_W-1:0];
                  default: begin
                    wr_valid_q  <= 1'b1;
                    wr_addr_q   <= ptr_q;
                    wr_data_q   <= shreg_q;
                    ptr_q       <= page_step(ptr_q);
                    data_seen_q <= 1'b1;
                  end
                endcase
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_q <= '0;
              if (kind_q == RX_CTRL && rw_q) begin
                txreg_q <= rd_data_i;
                ptr_q   <= seq_step(ptr_q);
                st_q    <= ST_TX;
              end else begin
                st_q   <= ST_RX;
                kind_q <= (kind_q == RX_CTRL) ? RX_ADDR : RX_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_q == BIT_W'(DATA_W - 1)) begin
                st_q  <= ST_MACK;
                bit_q <= '0;
              end else begin
                txreg_q <= {txreg_q[DATA_W-2:0], 1'b1};
                bit_q   <= bit_q + BIT_W'(1);
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_q) begin
                txreg_q <= rd_data_i;
                ptr_q   <= seq_step(ptr_q);
                st_q    <= ST_TX;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pull_req = (st_q == ST_ACK) | ((st_q == ST_TX) & ~txreg_q[DATA_W-1]);

  i2c_sda_hold #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .pull_req_i (pull_req),
    .scl_low_i  (~scl_lvl),
    .pull_o     (sda_pull_o)
  );

  assign rd_addr_o  = ptr_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign wr_stop_o  = wr_stop_q;

  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_ACK && $past(st_q) == ST_RX) |-> !$past(busy_i)); // R4
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> (st_q == ST_IDLE)); // R9
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n) wr_valid_o |-> (ptr_q[ADDR_W-1:PAGE_W] == wr_addr_o[ADDR_W-1:PAGE_W])); // R5
  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n) wr_stop_o |-> $past(stop_det)); // R6
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_TX && $past(st_q) != ST_TX) |-> (ptr_q == $past(ptr_q) + ADDR_W'(1))); // R7
endmodule

// File: tb/i2c_mem_slave_tb_top.sv
module i2c_mem_slave_tb_top;
  localparam int HALF = 20;
  localparam int QTR  = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic sda_pull, wr_valid, wr_stop, sda_bus;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;

  assign sda_bus = m_sda & ~sda_pull;

  logic [7:0] mem     [0:255];
  logic [7:0] exp_mem [0:255];
  logic [7:0] wlog_a  [0:63];
  logic [7:0] wlog_d  [0:63];
  int wcnt = 0, scnt = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  assign rd_data = mem[rd_addr];

  i2c_mem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .busy_i(busy), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_stop_o(wr_stop)
  );

  // Storage model and write log
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        mem[wr_addr] = wr_data;
        if (wcnt < 64) begin
          wlog_a[wcnt] = wr_addr;
          wlog_d[wcnt] = wr_data;
        end
        wcnt = wcnt + 1;
      end
      if (wr_stop) scnt = scnt + 1;
    end
  end

  function automatic logic [7:0] tb_page_next(input logic [7:0] a);
    return (a & 8'hF8) | ((a + 8'd1) & 8'h07);
  endfunction

  function automatic logic [7:0] ctrl(input bit rd);
    logic [2:0] blk;
    blk = 3'($urandom_range(0, 7));
    return {4'b1010, blk, rd};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clks(QTR);
    m_scl = 1'b1; wait_clks(HALF);
    m_sda = 1'b0; wait_clks(HALF);
    m_scl = 1'b0; wait_clks(QTR);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clks(QTR);
    m_scl = 1'b1; wait_clks(HALF);
    m_sda = 1'b1; wait_clks(HALF);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; wait_clks(QTR);
    m_scl = 1'b1; wait_clks(QTR);
    s = sda_bus; wait_clks(QTR);
    m_scl = 1'b0; wait_clks(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(~mack, s);
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d, input string req);
    bit ack;
    bus_start();
    send_byte(ctrl(1'b0), ack); chk(req, "write ctrl ack", ack, 1);
    send_byte(a, ack);          chk(req, "address ack", ack, 1);
    send_byte(d, ack);          chk(req, "data ack", ack, 1);
    bus_stop();
    exp_mem[a] = d;
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
    bit ack;
    bus_start();
    send_byte(ctrl(1'b0), ack); chk("R7", "setup ctrl ack", ack, 1);
    send_byte(a, ack);          chk("R7", "setup address ack", ack, 1);
    bus_start();
    send_byte(ctrl(1'b1), ack); chk("R2", "read ctrl ack", ack, 1);
    read_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic s;
    logic [7:0] d, a;
    int w0, s0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i) ^ 8'h5C;
      exp_mem[i] = 8'(i) ^ 8'h5C;
    end
    wait_clks(5);
    chk("R3", "pull in reset", sda_pull, 0);
    rst_n = 1'b1;
    wait_clks(5);
    chk("R3", "pull after reset", sda_pull, 0);
    chk("R3", "pointer after reset", rd_addr, 8'h00);
    chk("R5", "no write pulse after reset", wr_valid, 0);

    // Wrong control code: no acknowledge
    bus_start();
    send_byte(8'hB0, ack); chk("R2", "mismatched code ack", ack, 0);
    bus_stop();

    // Byte write with timing check of the ACK pull
    w0 = wcnt; s0 = scnt;
    bus_start();
    for (int i = 7; i >= 1; i--) clk_bit(ctrl(1'b0) >> i, s);
    m_sda = 1'b0; wait_clks(QTR); m_scl = 1'b1; wait_clks(HALF); m_scl = 1'b0; wait_clks(1);
    chk("R10", "pull right after SCL fall", sda_pull, 0);
    wait_clks(11);
    chk("R3", "pull in ack low phase", sda_pull, 1);
    clk_bit(1'b1, s); chk("R1", "ctrl ack", s, 0);
    send_byte(8'h10, ack); chk("R5", "address ack", ack, 1);
    send_byte(8'h5A, ack); chk("R5", "data ack", ack, 1);
    bus_stop();
    exp_mem[8'h10] = 8'h5A;
    chk("R5", "one write pulse", wcnt - w0, 1);
    chk("R5", "write address", wlog_a[w0], 8'h10);
    chk("R5", "write data", wlog_d[w0], 8'h5A);
    chk("R6", "one commit", scnt - s0, 1);

    // Page write of 10 bytes from 0x3D wraps in page 0x38
    w0 = wcnt; s0 = scnt;
    bus_start();
    send_byte(ctrl(1'b0), ack); chk("R2", "page ctrl ack", ack, 1);
    send_byte(8'h3D, ack);
    a = 8'h3D;
    for (int i = 0; i < 10; i++) begin
      send_byte(8'(i * 17 + 3), ack); chk("R5", "page data ack", ack, 1);
      exp_mem[a] = 8'(i * 17 + 3);
      chk("R5", "page wrap address", wlog_a[w0 + i], a);
      a = tb_page_next(a);
    end
    bus_stop();
    chk("R6", "page commit count", scnt - s0, 1);

    // Random read: repeated Start after address writes nothing
    w0 = wcnt; s0 = scnt;
    rand_read(8'h3A, d);
    chk("R7", "random read data", d, exp_mem[8'h3A]);
    chk("R6", "no write on read setup", wcnt - w0, 0);
    chk("R6", "no commit on read setup", scnt - s0, 0);

    // Current-address read continues from pointer
    bus_start();
    send_byte(ctrl(1'b1), ack); chk("R2", "current read ctrl ack", ack, 1);
    read_byte(1'b0, d);
    bus_stop();
    chk("R7", "current address read", d, exp_mem[8'h3B]);

    // Sequential read across the top of the array
    bus_start();
    send_byte(ctrl(1'b0), ack);
    send_byte(8'hFD, ack);
    bus_start();
    send_byte(ctrl(1'b1), ack);
    a = 8'hFD;
    for (int i = 0; i < 5; i++) begin
      read_byte(i != 4, d);
      chk("R8", "sequential byte", d, exp_mem[a]);
      a = a + 8'd1;
    end
    wait_clks(QTR);
    chk("R8", "released after NACK", sda_pull, 0);
    clk_bit(1'b1, s); chk("R8", "no drive after NACK", s, 1);
    bus_stop();

    // Busy: control byte ignored, then address ignored
    busy = 1'b1;
    bus_start();
    send_byte(ctrl(1'b0), ack); chk("R4", "ctrl ack while busy", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(ctrl(1'b0), ack); chk("R4", "ctrl ack after busy", ack, 1);
    busy = 1'b1;
    send_byte(8'h90, ack); chk("R4", "address ack while busy", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(ctrl(1'b1), ack);
    read_byte(1'b0, d);
    bus_stop();
    chk("R4", "pointer kept while busy", d, exp_mem[8'h02]);

    // Start in mid-byte restarts control reception
    w0 = wcnt;
    bus_start();
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
    bus_start();
    send_byte(ctrl(1'b0), ack); chk("R9", "ctrl ack after restart", ack, 1);
    send_byte(8'h80, ack);
    send_byte(8'hC3, ack);
    bus_stop();
    exp_mem[8'h80] = 8'hC3;
    chk("R9", "write after restart address", wlog_a[w0], 8'h80);

    // Stop in mid-byte: later clocks get no ACK
    bus_start();
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    bus_stop();
    m_scl = 1'b0; wait_clks(QTR);
    send_byte(8'hA0, ack); chk("R9", "no ack after mid-byte stop", ack, 0);
    bus_stop();

    // Random writes and reads
    for (int k = 0; k < 12; k++) begin
      logic [7:0] ra, rd, rb;
      ra = 8'($urandom); rd = 8'($urandom);
      wr_byte(ra, rd, "R5");
      rand_read(ra, d);
      chk("R7", "random readback", d, exp_mem[ra]);
      rb = 8'($urandom);
      rand_read(rb, d);
      chk("R7", "random other address", d, exp_mem[rb]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule